// File: doc/BRIEF.md
# Flash Command Interpreter with Write Status

The block sits behind the bus front end of a byte-wide flash device. It accepts byte writes, each an address and a data byte. From them it decodes one-cycle mode commands and two-cycle operation commands. It chooses what a read returns through the read-mode select: the array, the identifier space or the status byte. Erase and program operations go to an array model as a one-cycle request carrying kind, address and data. Each accepted operation holds the block busy for a cycle count taken from a configuration input.

The block owns the volatile protection state:
- a whole-device lock, set by every reset;
- one lock bit per boot sector;
- two pin-level protect inputs.

A protected attempt, an unknown byte or a malformed sequence does not reach the array. Instead it sets flags in an 8-bit status byte, which stays readable while the block is busy. The ready output reports the same thing as status bit 7.

Controller states:
- `FS_IDLE` accepts mode commands and first bytes.
- `FS_ARMED` waits for the second byte of a two-cycle command.
- `FS_BUSY` waits for the busy timer to expire.

Transitions:
- IDLE→ARMED on 20h, 30h, 40h, 10h or 60h.
- ARMED→BUSY on an accepted second byte.
- ARMED→IDLE on a rejected or unknown second byte.
- BUSY→IDLE on the last timer cycle.
- Any state→IDLE on reset.

Top module: `fcmd_ctrl`

## Requirements
- R1: After reset: `rd_mode` is 0 (array), `status` is 80h, `ready` is 1, `op_req` is 0 and the whole-device lock is set.
- R2: One-cycle commands in IDLE:
  - FFh sets `rd_mode` 0.
  - 90h sets `rd_mode` 1 (identifier).
  - 70h sets `rd_mode` 2 (status).
  - 50h clears status bits 5, 4 and 1 and sets `rd_mode` 0.
- R3: Operations reach the array as follows:
  - 20h then D0h gives `op_kind` 0 (sector/block erase) at the second-cycle address.
  - 30h then D0h gives `op_kind` 1 (chip erase).
  - 40h or 10h then any byte gives `op_kind` 2 (program) with that byte as `op_data`.
  - An accepted operation pulses `op_req` for exactly one cycle, with kind, address and data valid in that cycle.
  - The first byte of a two-cycle command and any accepted, rejected or protected second byte (apart from those that R10 sends back to array mode) set `rd_mode` 2.
- R4: `ready` drops in the cycle after an accepted operation and stays low for exactly N cycles. N is `cfg_erase_cyc` for either erase, `cfg_prog_cyc` for program and `cfg_lock_cyc` for lock commands; a count of 0 acts as 1. `ready` always equals `status[7]`.
- R5: Status bit 6 inverts at each clock edge where `stat_rd` is high while busy. It holds its value while ready.
- R6: Status bits 5, 4 and 1 read 0 while busy. Bits 3, 2 and 0 always read 0.
- R7: While the whole-device lock is set, every erase or program attempt sets bit 1, plus bit 5 (erase) or bit 4 (program). It produces no `op_req` and no busy period.
- R8: Addresses with the top nibble Fh are boot sectors, indexed by address bits 15:13. A boot sector is protected when `tbl_n` is 0 and its lock bit is 1. Any other address is protected when `wp_n` is 0. A chip erase is protected when `wp_n` is 0, or when `tbl_n` is 0 and any boot lock bit is 1. Protection failures flag as in R7.
- R9: Lock commands start with 60h. The second byte then does the following:
  - BBh sets the whole-device lock.
  - DBh clears it.
  - 01h sets the lock bit of the addressed boot sector.
  - D0h clears all boot lock bits.
  - Each is busy for the lock count and raises no `op_req`.
- R10: An unknown first byte, an unknown second byte, or 60h/01h at a non-boot address sets status bits 5 and 4 and returns `rd_mode` to 0.
- R11: Writes received while busy are ignored: mode, flags and locks do not change.
- R12: Either reset input, when low, aborts any operation. The block returns to the R1 state and all boot lock bits are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_a_n | input | 1 | First active-low reset, OR-ed with the second |
| rst_b_n | input | 1 | Second active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data / command byte |
| stat_rd | input | 1 | Status read strobe (drives the toggle bit) |
| tbl_n | input | 1 | Boot-sector protect pin, active low |
| wp_n | input | 1 | Main-block protect pin, active low |
| cfg_erase_cyc | input | CNT_W | Busy cycles for erase |
| cfg_prog_cyc | input | CNT_W | Busy cycles for program |
| cfg_lock_cyc | input | CNT_W | Busy cycles for lock commands |
| rd_mode | output | 2 | 0 array, 1 identifier, 2 status |
| status | output | 8 | Status byte |
| ready | output | 1 | High when no operation runs |
| op_req | output | 1 | One-cycle operation request to the array |
| op_kind | output | 2 | 0 sector/block erase, 1 chip erase, 2 program |
| op_addr | output | ADDR_W | Operation address |
| op_data | output | 8 | Program data |

## Verification
Directed sequences walk every lock and protection combination. They cover the locked device, a locked boot sector with the boot pin low and then high, an unlocked neighbour sector, a main block under the protect pin, and chip erase against boot locks. Each accepted-versus-flagged outcome shows which protection layer made the decision. Random streams mix valid commands, unknown bytes and orphan second bytes at boot and non-boot addresses. They also flip pins between operations, which separates the first-cycle and second-cycle decoders. Busy windows are probed with status reads and injected writes, which shows toggle counting, flag masking and write rejection at the exact cycle. Resets applied through each input in mid-operation show the abort path.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_IDENT  = 2'd1,
        RM_STATUS = 2'd2
    } rd_mode_e;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_ARMED,
        FS_BUSY
    } fsm_e;

    typedef enum logic [2:0] {
        PC_NONE,
        PC_ERASE,
        PC_CHIP,
        PC_PROG,
        PC_LOCK
    } pend_e;

    typedef enum logic [1:0] {
        OK_SECTOR = 2'd0,
        OK_CHIP   = 2'd1,
        OK_PROG   = 2'd2
    } op_kind_e;

    localparam logic [7:0] CMD_ARRAY   = 8'hFF;
    localparam logic [7:0] CMD_CLRST   = 8'h50;
    localparam logic [7:0] CMD_IDENT   = 8'h90;
    localparam logic [7:0] CMD_STAT    = 8'h70;
    localparam logic [7:0] CMD_ERASE   = 8'h20;
    localparam logic [7:0] CMD_CHIP    = 8'h30;
    localparam logic [7:0] CMD_PROG_A  = 8'h40;
    localparam logic [7:0] CMD_PROG_B  = 8'h10;
    localparam logic [7:0] CMD_LOCK    = 8'h60;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;
    localparam logic [7:0] CMD_WL_SET  = 8'hBB;
    localparam logic [7:0] CMD_WL_CLR  = 8'hDB;
    localparam logic [7:0] CMD_BL_SET  = 8'h01;

endpackage

// File: rtl/fcmd_busy_timer.sv
module fcmd_busy_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             busy,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= (len == '0) ? CNT_W'(1) : len;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign busy = (cnt_q != '0);
    assign last = (cnt_q == CNT_W'(1));

    // R11
    load_idle_chk: assert property (@(posedge clk) disable iff (rst)
        load |-> !busy);

    // R4
    last_ends_chk: assert property (@(posedge clk) disable iff (rst)
        last |=> !busy);

endmodule

// File: rtl/fcmd_protect.sv
module fcmd_protect #(
    parameter int ADDR_W    = 20,
    parameter int BOOT_SECT = 8
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wlock,
    input  logic [BOOT_SECT-1:0] boot_lock,
    input  logic                 tbl_n,
    input  logic                 wp_n,
    output logic                 in_boot,
    output logic [BOOT_SECT-1:0] sec_hit,
    output logic                 blk_one,
    output logic                 blk_chip
);

    localparam int SEC_W   = $clog2(BOOT_SECT);
    localparam int TOP_W   = 4;
    localparam int SEC_LSB = ADDR_W - TOP_W - SEC_W;

    logic [SEC_W-1:0]     idx;
    logic [BOOT_SECT-1:0] guard;

    assign in_boot = &addr[ADDR_W-1 -: TOP_W];
    assign idx     = addr[SEC_LSB +: SEC_W];

    for (genvar i = 0; i < BOOT_SECT; i++) begin : g_sec
        assign sec_hit[i] = in_boot && (idx == SEC_W'(i));
        assign guard[i]   = sec_hit[i] & ~tbl_n & boot_lock[i];
    end

    assign blk_one  = wlock | (in_boot ? (|guard) : ~wp_n);
    assign blk_chip = wlock | ~wp_n | (~tbl_n & (|boot_lock));

endmodule

// File: rtl/fcmd_ctrl.sv
module fcmd_ctrl
    import fcmd_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int CNT_W     = 16,
    parameter int BOOT_SECT = 8
) (
    input  logic              clk,
    input  logic              rst_a_n,
    input  logic              rst_b_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              stat_rd,
    input  logic              tbl_n,
    input  logic              wp_n,
    input  logic [CNT_W-1:0]  cfg_erase_cyc,
    input  logic [CNT_W-1:0]  cfg_prog_cyc,
    input  logic [CNT_W-1:0]  cfg_lock_cyc,
    output logic [1:0]        rd_mode,
    output logic [7:0]        status,
    output logic              ready,
    output logic              op_req,
    output logic [1:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data
);

    logic rst;
    assign rst = ~(rst_a_n & rst_b_n);

    fsm_e     state_q, state_d;
    pend_e    pend_q, pend_d;
    rd_mode_e mode_q, mode_d;

    logic                 e5_q, e4_q, ep_q, tog_q, wlock_q;
    logic [BOOT_SECT-1:0] boot_q;

    logic             set5, set4, setp, clr_err, bad, launch;
    logic             wl_set, wl_clr, bl_set, bl_clr;
    op_kind_e         kind_d;
    logic             t_load, t_busy, t_last;
    logic [CNT_W-1:0] t_len;

    logic                 in_boot, blk_one, blk_chip;
    logic [BOOT_SECT-1:0] sec_hit;

    fcmd_protect #(.ADDR_W(ADDR_W), .BOOT_SECT(BOOT_SECT)) u_prot (
        .addr     (wr_addr),
        .wlock    (wlock_q),
        .boot_lock(boot_q),
        .tbl_n    (tbl_n),
        .wp_n     (wp_n),
        .in_boot  (in_boot),
        .sec_hit  (sec_hit),
        .blk_one  (blk_one),
        .blk_chip (blk_chip)
    );

    fcmd_busy_timer #(.CNT_W(CNT_W)) u_timer (
        .clk (clk),
        .rst (rst),
        .load(t_load),
        .len (t_len),
        .busy(t_busy),
        .last(t_last)
    );

    // decode and next-state
    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        mode_d  = mode_q;
        set5 = 1'b0; set4 = 1'b0; setp = 1'b0; clr_err = 1'b0; bad = 1'b0;
        launch = 1'b0; kind_d = OK_SECTOR;
        t_load = 1'b0; t_len = '0;
        wl_set = 1'b0; wl_clr = 1'b0; bl_set = 1'b0; bl_clr = 1'b0;
        unique case (state_q)
            FS_IDLE: begin
                if (wr_en) begin
                    case (wr_data)
                        CMD_ARRAY: mode_d = RM_ARRAY;
                        CMD_CLRST: begin mode_d = RM_ARRAY; clr_err = 1'b1; end
                        CMD_IDENT: mode_d = RM_IDENT;
                        CMD_STAT:  mode_d = RM_STATUS;
                        CMD_ERASE: begin pend_d = PC_ERASE; state_d = FS_ARMED; mode_d = RM_STATUS; end
                        CMD_CHIP:  begin pend_d = PC_CHIP;  state_d = FS_ARMED; mode_d = RM_STATUS; end
                        CMD_PROG_A,
                        CMD_PROG_B: begin pend_d = PC_PROG; state_d = FS_ARMED; mode_d = RM_STATUS; end
                        CMD_LOCK:  begin pend_d = PC_LOCK;  state_d = FS_ARMED; mode_d = RM_STATUS; end
                        default:   bad = 1'b1;
                    endcase
                end
            end
            FS_ARMED: begin
                if (wr_en) begin
                    state_d = FS_IDLE;
                    pend_d  = PC_NONE;
                    mode_d  = RM_STATUS;
                    unique case (pend_q)
                        PC_ERASE: begin
                            if (wr_data != CMD_CONFIRM) bad = 1'b1;
                            else if (blk_one) begin setp = 1'b1; set5 = 1'b1; end
                            else begin
                                launch = 1'b1; kind_d = OK_SECTOR;
                                t_load = 1'b1; t_len = cfg_erase_cyc; state_d = FS_BUSY;
                            end
                        end
                        PC_CHIP: begin
                            if (wr_data != CMD_CONFIRM) bad = 1'b1;
                            else if (blk_chip) begin setp = 1'b1; set5 = 1'b1; end
                            else begin
                                launch = 1'b1; kind_d = OK_CHIP;
                                t_load = 1'b1; t_len = cfg_erase_cyc; state_d = FS_BUSY;
                            end
                        end
                        PC_PROG: begin
                            if (blk_one) begin setp = 1'b1; set4 = 1'b1; end
                            else begin
                                launch = 1'b1; kind_d = OK_PROG;
                                t_load = 1'b1; t_len = cfg_prog_cyc; state_d = FS_BUSY;
                            end
                        end
                        PC_LOCK: begin
                            case (wr_data)
                                CMD_WL_SET:  wl_set = 1'b1;
                                CMD_WL_CLR:  wl_clr = 1'b1;
                                CMD_BL_SET:  if (in_boot) bl_set = 1'b1; else bad = 1'b1;
                                CMD_CONFIRM: bl_clr = 1'b1;
                                default:     bad = 1'b1;
                            endcase
                            if (!bad) begin
                                t_load = 1'b1; t_len = cfg_lock_cyc; state_d = FS_BUSY;
                            end
                        end
                        default: bad = 1'b1;
                    endcase
                end
            end
            FS_BUSY: begin
                if (t_last) state_d = FS_IDLE;
            end
            default: state_d = FS_IDLE;
        endcase
        if (bad) begin
            set5 = 1'b1; set4 = 1'b1; mode_d = RM_ARRAY;
        end
    end

    // state register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= FS_IDLE;
            pend_q  <= PC_NONE;
            mode_q  <= RM_ARRAY;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            mode_q  <= mode_d;
        end
    end

    // flags, locks and request outputs
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            e5_q    <= 1'b0;
            e4_q    <= 1'b0;
            ep_q    <= 1'b0;
            tog_q   <= 1'b0;
            wlock_q <= 1'b1;
            boot_q  <= '0;
            op_req  <= 1'b0;
            op_kind <= OK_SECTOR;
            op_addr <= '0;
            op_data <= '0;
        end else begin
            if (clr_err) begin
                e5_q <= 1'b0; e4_q <= 1'b0; ep_q <= 1'b0;
            end else begin
                e5_q <= e5_q | set5;
                e4_q <= e4_q | set4;
                ep_q <= ep_q | setp;
            end
            if (stat_rd && t_busy) tog_q <= ~tog_q;
            if (wl_set) wlock_q <= 1'b1;
            else if (wl_clr) wlock_q <= 1'b0;
            if (bl_set) boot_q <= boot_q | sec_hit;
            else if (bl_clr) boot_q <= '0;
            op_req <= launch;
            if (launch) begin
                op_kind <= kind_d;
                op_addr <= wr_addr;
                op_data <= wr_data;
            end
        end
    end

    assign rd_mode = mode_q;
    assign ready   = ~t_busy;
    assign status  = {ready, tog_q, ready & e5_q, ready & e4_q, 1'b0, 1'b0, ready & ep_q, 1'b0};

    // R4
    state_busy_match_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == FS_BUSY) == t_busy);

    // R3
    op_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        op_req |=> !op_req);

    // R3
    op_busy_chk: assert property (@(posedge clk) disable iff (rst)
        op_req |-> !ready);

    // R5
    tog_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ready |=> $stable(tog_q));

    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == FS_BUSY && wr_en) |=> ($stable(mode_q) && $stable(wlock_q) && $stable(boot_q)));

    // R12
    lock_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (wlock_q && boot_q == '0));

endmodule

// File: tb/tb_fcmd_ctrl.sv
`timescale 1ns/1ps
module tb_fcmd_ctrl;

    logic        clk = 1'b0;
    logic        rst_a_n = 1'b0, rst_b_n = 1'b1;
    logic        wr_en = 1'b0, stat_rd = 1'b0;
    logic [19:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        tbl_n = 1'b1, wp_n = 1'b1;
    logic [15:0] cfg_erase_cyc = 16'd5, cfg_prog_cyc = 16'd3, cfg_lock_cyc = 16'd2;
    logic [1:0]  rd_mode;
    logic [7:0]  status;
    logic        ready, op_req;
    logic [1:0]  op_kind;
    logic [19:0] op_addr;
    logic [7:0]  op_data;

    int n_tests = 0, n_fail = 0;

    // reference model state
    int   m_mode, m_pend;
    bit   m_e5, m_e4, m_ep, m_tog, m_wl, m_armed;
    logic [7:0] m_boot;

    always #2.5 clk = ~clk;

    fcmd_ctrl dut (
        .clk(clk), .rst_a_n(rst_a_n), .rst_b_n(rst_b_n), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .stat_rd(stat_rd),
        .tbl_n(tbl_n), .wp_n(wp_n), .cfg_erase_cyc(cfg_erase_cyc),
        .cfg_prog_cyc(cfg_prog_cyc), .cfg_lock_cyc(cfg_lock_cyc),
        .rd_mode(rd_mode), .status(status), .ready(ready), .op_req(op_req),
        .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int exp_status(input bit rdy);
        return {24'd0, rdy, m_tog, rdy & m_e5, rdy & m_e4, 2'b00, rdy & m_ep, 1'b0};
    endfunction

    function automatic int eff(input logic [15:0] n);
        return (n == 0) ? 1 : int'(n);
    endfunction

    task automatic model_reset();
        m_mode = 0; m_pend = 0; m_e5 = 0; m_e4 = 0; m_ep = 0;
        m_tog = 0; m_wl = 1; m_armed = 0; m_boot = '0;
    endtask

    task automatic model_wr(input logic [19:0] a, input logic [7:0] d,
                            output bit go, output int len, output int kind);
        bit isb   = (a[19:16] == 4'hF);
        int si    = int'(a[15:13]);
        bit b_one = m_wl || (isb ? (!tbl_n && m_boot[si]) : !wp_n);
        bit b_chp = m_wl || !wp_n || (!tbl_n && (m_boot != 0));
        bit bad   = 0;
        go = 0; len = 0; kind = 0;
        if (!m_armed) begin
            case (d)
                8'hFF: m_mode = 0;
                8'h50: begin m_mode = 0; m_e5 = 0; m_e4 = 0; m_ep = 0; end
                8'h90: m_mode = 1;
                8'h70: m_mode = 2;
                8'h20: begin m_armed = 1; m_pend = 1; m_mode = 2; end
                8'h30: begin m_armed = 1; m_pend = 2; m_mode = 2; end
                8'h40, 8'h10: begin m_armed = 1; m_pend = 3; m_mode = 2; end
                8'h60: begin m_armed = 1; m_pend = 4; m_mode = 2; end
                default: bad = 1;
            endcase
        end else begin
            m_armed = 0; m_mode = 2;
            case (m_pend)
                1: if (d != 8'hD0) bad = 1;
                   else if (b_one) begin m_ep = 1; m_e5 = 1; end
                   else begin go = 1; kind = 0; len = eff(cfg_erase_cyc); end
                2: if (d != 8'hD0) bad = 1;
                   else if (b_chp) begin m_ep = 1; m_e5 = 1; end
                   else begin go = 1; kind = 1; len = eff(cfg_erase_cyc); end
                3: if (b_one) begin m_ep = 1; m_e4 = 1; end
                   else begin go = 1; kind = 2; len = eff(cfg_prog_cyc); end
                default: begin
                    case (d)
                        8'hBB: m_wl = 1;
                        8'hDB: m_wl = 0;
                        8'h01: if (isb) m_boot[si] = 1'b1; else bad = 1;
                        8'hD0: m_boot = '0;
                        default: bad = 1;
                    endcase
                    if (!bad) len = eff(cfg_lock_cyc);
                end
            endcase
        end
        if (bad) begin m_e5 = 1; m_e4 = 1; m_mode = 0; end
    endtask

    task automatic wait_busy(input string tag, input int len, input bit inject);
        for (int i = 1; i <= len; i++) begin
            stat_rd = 1'b1;
            if (inject && i == 1) begin
                wr_en = 1'b1; wr_data = 8'hFF; wr_addr = 20'h00000;
            end
            @(posedge clk); @(negedge clk);
            stat_rd = 1'b0; wr_en = 1'b0;
            m_tog = ~m_tog;
            chk(tag, "ready during busy", int'(ready), (i == len) ? 1 : 0);
        end
        chk(tag, "mode after busy", int'(rd_mode), m_mode);
        chk(tag, "status after busy", int'(status), exp_status(1'b1));
    endtask

    task automatic wr(input string tag, input logic [19:0] a, input logic [7:0] d, input bit inject);
        bit go; int len; int kind;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        model_wr(a, d, go, len, kind);
        chk(tag, "op_req", int'(op_req), int'(go));
        if (go) begin
            chk(tag, "op_kind", int'(op_kind), kind);
            chk(tag, "op_addr", int'(op_addr), int'(a));
            chk(tag, "op_data", int'(op_data), int'(d));
        end
        chk(tag, "ready", int'(ready), (len == 0) ? 1 : 0);
        chk(tag, "rd_mode", int'(rd_mode), m_mode);
        chk(tag, "status", int'(status), exp_status(len == 0));
        if (len > 0) wait_busy(tag, len, inject);
    endtask

    task automatic do_reset(input string tag, input bit use_b);
        if (use_b) rst_b_n = 1'b0; else rst_a_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_a_n = 1'b1; rst_b_n = 1'b1;
        model_reset();
        @(negedge clk);
        chk(tag, "reset rd_mode", int'(rd_mode), 0);
        chk(tag, "reset status", int'(status), 8'h80);
        chk(tag, "reset ready", int'(ready), 1);
        chk(tag, "reset op_req", int'(op_req), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R4 watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        // R1: reset through the first input
        do_reset("R1", 1'b0);
        // R7: program with whole lock set after reset
        wr("R7", 20'h00123, 8'h40, 0);
        wr("R7", 20'h00123, 8'hAA, 0);
        chk("R7", "locked program status", int'(status), 8'h92);
        wr("R7", 20'h40000, 8'h20, 0);
        wr("R7", 20'h40000, 8'hD0, 0);
        // R2: one-cycle commands
        wr("R2", 20'h0, 8'h50, 0);
        chk("R2", "cleared status", int'(status), 8'h80);
        wr("R2", 20'h0, 8'h90, 0);
        chk("R2", "ident mode", int'(rd_mode), 1);
        wr("R2", 20'h0, 8'h70, 0);
        wr("R2", 20'h0, 8'hFF, 0);
        // R9: clear whole lock
        wr("R9", 20'h0, 8'h60, 0);
        wr("R9", 20'h0, 8'hDB, 0);
        // R3 R4 R5 R11: program with toggling and a write during busy
        wr("R3", 20'h12345, 8'h10, 0);
        wr("R3", 20'h12345, 8'h5A, 1);
        wr("R11", 20'h0, 8'h30, 0);
        wr("R11", 20'h0, 8'hD0, 1);
        wr("R3", 20'h70000, 8'h20, 0);
        wr("R3", 20'h70000, 8'hD0, 0);
        // R8: boot lock on sector 3
        wr("R9", 20'hF6000, 8'h60, 0);
        wr("R9", 20'hF6000, 8'h01, 0);
        tbl_n = 1'b0;
        wr("R8", 20'hF6010, 8'h40, 0);
        wr("R8", 20'hF6010, 8'h33, 0);
        chk("R8", "boot protect flag", int'(status[1]), 1);
        wr("R8", 20'hF2000, 8'h40, 0);
        wr("R8", 20'hF2000, 8'h44, 0);
        wr("R8", 20'h0, 8'h30, 0);
        wr("R8", 20'h0, 8'hD0, 0);
        tbl_n = 1'b1;
        wr("R8", 20'hF6010, 8'h40, 0);
        wr("R8", 20'hF6010, 8'h33, 0);
        wp_n = 1'b0;
        wr("R8", 20'h30000, 8'h20, 0);
        wr("R8", 20'h30000, 8'hD0, 0);
        wr("R8", 20'hF6000, 8'h20, 0);
        wr("R8", 20'hF6000, 8'hD0, 0);
        wp_n = 1'b1; tbl_n = 1'b0;
        wr("R9", 20'h0, 8'h60, 0);
        wr("R9", 20'h0, 8'hD0, 0);
        wr("R8", 20'h0, 8'h30, 0);
        wr("R8", 20'h0, 8'hD0, 0);
        tbl_n = 1'b1;
        // R6: flags masked while busy
        wr("R6", 20'h0, 8'h77, 0);
        wr("R6", 20'h00010, 8'h40, 0);
        wr("R6", 20'h00010, 8'h01, 0);
        // R10: bad sequences
        wr("R10", 20'h0, 8'h50, 0);
        wr("R10", 20'h10000, 8'h60, 0);
        wr("R10", 20'h10000, 8'h01, 0);
        chk("R10", "bad lock status", int'(status), 8'hB0);
        wr("R10", 20'h0, 8'h20, 0);
        wr("R10", 20'h0, 8'h55, 0);
        wr("R10", 20'h0, 8'h60, 0);
        wr("R10", 20'h0, 8'h12, 0);
        // R4: zero count behaves as one
        cfg_prog_cyc = 16'd0;
        wr("R4", 20'h00500, 8'h40, 0);
        wr("R4", 20'h00500, 8'hC3, 0);
        cfg_prog_cyc = 16'd3;
        // R12: reset through the second input in mid-operation
        wr("R12", 20'h20000, 8'h20, 0);
        wr_en = 1'b1; wr_addr = 20'h20000; wr_data = 8'hD0;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        chk("R12", "busy before reset", int'(ready), 0);
        do_reset("R12", 1'b1);
        wr("R12", 20'h00001, 8'h40, 0);
        wr("R12", 20'h00001, 8'h99, 0);
        chk("R12", "lock restored", int'(status[1]), 1);
        // random stream
        wr("RND", 20'h0, 8'h60, 0);
        wr("RND", 20'h0, 8'hDB, 0);
        for (int k = 0; k < 400; k++) begin
            logic [7:0]  d;
            logic [19:0] a;
            int pick = int'($urandom_range(0, 15));
            if ($urandom_range(0, 7) == 0) tbl_n = $urandom_range(0, 1) != 0;
            if ($urandom_range(0, 7) == 0) wp_n  = $urandom_range(0, 1) != 0;
            a = ($urandom_range(0, 1) != 0) ? {4'hF, 16'($urandom())}
                                            : {4'($urandom_range(0, 14)), 16'($urandom())};
            if (!m_armed) begin
                case (pick)
                    0: d = 8'hFF; 1: d = 8'h50; 2: d = 8'h90; 3: d = 8'h70;
                    4, 5: d = 8'h20; 6: d = 8'h30; 7: d = 8'h40; 8: d = 8'h10;
                    9, 10, 11: d = 8'h60;
                    default: d = 8'($urandom());
                endcase
            end else begin
                case (pick)
                    0, 1, 2, 3: d = 8'hD0; 4: d = 8'hBB; 5, 6: d = 8'hDB;
                    7, 8: d = 8'h01;
                    default: d = 8'($urandom());
                endcase
            end
            wr("RND", a, d, pick[0]);
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule